// File: doc/BRIEF.md
# Per-Sector CRC Inserter and Checker

This block sits in a flash controller's byte stream, between the host-side data and the error-correction engine. In the write direction it computes a 64-bit CRC over every sector of payload. It places the eight checksum bytes straight after the last payload byte of that sector, with no gap. In the read direction it recomputes the checksum over each arriving sector and compares it with the eight bytes that follow. It removes those eight bytes from the stream. A mismatch raises a one-cycle data-integrity error together with a one-cycle request to reset the controller's thread. Because the checksum travels inside the protected area, enabling it leaves eight fewer bytes for protected metadata.

Both sides of the block are byte-wide valid/ready streams, and the block stores no data. Payload bytes flow combinationally from input to output. Only the 64-bit checksum register and a byte counter hold state. Three configuration inputs control the block: the CRC enable, the direction and the sector length. They are taken only while the controller reports idle, so a transfer always runs with the settings it started with.

The checksum uses the generator 0x42F0E1EBA9EA3693 with an all-zero start value, no bit reflection and no output inversion. It restarts at every sector.

Top module: `sector_crc_guard`

## Requirements
- R1: While `idle` is high the block accepts no input and emits no output (`in_ready` = 0, `out_valid` = 0). It samples `crc_en`, `rd_mode` and `sect_len` on each clock edge during that time.
- R2: With the CRC disabled, every input byte appears unchanged at the output in the same order. No bytes are added or removed.
- R3: In write mode (`rd_mode` = 0) with the CRC enabled, the block emits each sector's `sect_len` payload bytes and then the 8 checksum bytes, most significant byte first, with no gap. The checksum uses generator 0x42F0E1EBA9EA3693 with initial value 0, no reflection and no final XOR. For the nine ASCII bytes "123456789" it is 0x6C40DF5F0B497347.
- R4: In read mode (`rd_mode` = 1) with the CRC enabled, the block forwards each sector's `sect_len` payload bytes. It consumes the next 8 bytes as the stored checksum and does not pass them downstream.
- R5: If any stored checksum byte differs from the recomputed checksum, `data_err` and `thread_rst_req` are both high for exactly one cycle. That cycle is the one after the clock edge that takes the eighth checksum byte. A corrupted payload byte and a corrupted checksum byte both count as a mismatch.
- R6: A sector whose stored checksum matches produces no pulse on `data_err` or `thread_rst_req`. Write mode and bypass never produce one.
- R7: Sectors follow back to back within one transfer. The checksum and the byte count restart at each sector start, and a sector length of 1 is supported.
- R8: While a write-mode checksum byte is offered and `out_ready` is low, `out_data` holds its value.
- R9: Changes to `crc_en`, `rd_mode` or `sect_len` while `idle` is low have no effect on the running transfer.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low reset |
| idle | input | 1 | Controller idle; configuration is sampled and sector state cleared while high |
| crc_en | input | 1 | Enables checksum insertion or checking |
| rd_mode | input | 1 | 0 = write (insert), 1 = read (check and strip) |
| sect_len | input | LEN_W | Payload bytes per sector, at least 1 |
| in_valid | input | 1 | Upstream byte valid |
| in_data | input | 8 | Upstream byte |
| in_ready | output | 1 | Block accepts the upstream byte |
| out_valid | output | 1 | Downstream byte valid |
| out_data | output | 8 | Downstream byte |
| out_ready | input | 1 | Downstream accepts the byte |
| data_err | output | 1 | One-cycle checksum mismatch flag |
| thread_rst_req | output | 1 | One-cycle automatic thread-reset request |

## Verification
The bench builds the block with LEN_W = 12 and runs sector lengths of 1, 3 to 6 and 9. The single-byte sectors place a sector boundary on every payload byte, so the counter wraps straight from the checksum phase back into the last payload byte. The nine-byte sector fed with "123456789" pins the checksum against its known check value. Random stalls on both sides of the stream reach stalls inside the checksum phase. Mid-transfer flips of enable and length expose any configuration that is not latched.

// File: rtl/sector_crc_guard.sv
module sector_crc_guard #(
  parameter int LEN_W = 12,
  parameter logic [63:0] POLY = 64'h42F0E1EBA9EA3693
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             idle,
  input  logic             crc_en,
  input  logic             rd_mode,
  input  logic [LEN_W-1:0] sect_len,
  input  logic             in_valid,
  input  logic [7:0]       in_data,
  output logic             in_ready,
  output logic             out_valid,
  output logic [7:0]       out_data,
  input  logic             out_ready,
  output logic             data_err,
  output logic             thread_rst_req
);

  localparam int TAIL_N = 8;

  logic             en_q, rd_q, tail, mis_q, err_q;
  logic [LEN_W-1:0] len_q, cnt;
  logic [63:0]      crc_q, crc_sh;
  logic [7:0]       tail_byte;
  logic             wr_tail, rd_tail, in_hs, out_hs, step, last_data, last_tail, byte_bad;

  function automatic logic [63:0] crc_byte(input logic [63:0] c, input logic [7:0] b);
    logic [63:0] r;
    r = c;
    for (int i = 7; i >= 0; i--) begin
      if (r[63] ^ b[i]) r = {r[62:0], 1'b0} ^ POLY;
      else              r = {r[62:0], 1'b0};
    end
    return r;
  endfunction

  assign wr_tail   = en_q && !rd_q && tail;
  assign rd_tail   = en_q &&  rd_q && tail;
  assign crc_sh    = crc_q << {cnt[2:0], 3'b000};
  assign tail_byte = crc_sh[63:56];

  assign out_valid = !idle && (wr_tail || (!rd_tail && in_valid));
  assign in_ready  = !idle && (rd_tail || (!wr_tail && out_ready));
  assign out_data  = wr_tail ? tail_byte : in_data;

  assign in_hs     = in_valid && in_ready;
  assign out_hs    = out_valid && out_ready;
  assign step      = wr_tail ? out_hs : in_hs;
  assign last_data = (cnt == len_q - LEN_W'(1));
  assign last_tail = (cnt == LEN_W'(TAIL_N - 1));
  assign byte_bad  = (in_data != tail_byte);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      en_q  <= 1'b0;
      rd_q  <= 1'b0;
      len_q <= LEN_W'(1);
      cnt   <= '0;
      tail  <= 1'b0;
      crc_q <= '0;
      mis_q <= 1'b0;
      err_q <= 1'b0;
    end else begin
      err_q <= 1'b0;
      if (idle) begin
        en_q  <= crc_en;
        rd_q  <= rd_mode;
        len_q <= sect_len;
        cnt   <= '0;
        tail  <= 1'b0;
        crc_q <= '0;
        mis_q <= 1'b0;
      end else if (en_q && step) begin
        if (!tail) begin
          crc_q <= crc_byte(crc_q, in_data);
          if (last_data) begin
            tail <= 1'b1;
            cnt  <= '0;
          end else begin
            cnt <= cnt + LEN_W'(1);
          end
        end else begin
          if (rd_q) mis_q <= mis_q | byte_bad;
          if (last_tail) begin
            tail  <= 1'b0;
            cnt   <= '0;
            crc_q <= '0;
            mis_q <= 1'b0;
            if (rd_q) err_q <= mis_q | byte_bad;
          end else begin
            cnt <= cnt + LEN_W'(1);
          end
        end
      end
    end
  end

  assign data_err       = err_q;
  assign thread_rst_req = err_q;

  a_r1_idle_quiet: assert property (@(posedge clk) disable iff (!rst_n)
    idle |-> (!in_ready && !out_valid));

  a_r4_strip_tail: assert property (@(posedge clk) disable iff (!rst_n)
    rd_tail |-> !out_valid);

  a_r5_err_read_only: assert property (@(posedge clk) disable iff (!rst_n)
    data_err |-> $past(en_q && rd_q && tail));

  a_r7_tail_count: assert property (@(posedge clk) disable iff (!rst_n)
    tail |-> (cnt < LEN_W'(TAIL_N)));

  a_r7_data_count: assert property (@(posedge clk) disable iff (!rst_n)
    (en_q && !tail && !idle && len_q != '0) |-> (cnt < len_q));

  a_r8_tail_hold: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_tail && !idle && !out_ready) |=> (idle || $stable(out_data)));

endmodule

// File: tb/sector_crc_guard_test.sv
`timescale 1ns/1ps
module sector_crc_guard_test;
  localparam int LEN_W = 12;
  localparam logic [63:0] GEN = 64'h42F0E1EBA9EA3693;

  logic clk = 1'b0, rst_n = 1'b0, idle = 1'b1, crc_en = 1'b0, rd_mode = 1'b0;
  logic [LEN_W-1:0] sect_len = LEN_W'(1);
  logic in_valid = 1'b0, out_ready = 1'b0;
  logic [7:0] in_data = 8'h00;
  logic in_ready, out_valid, data_err, thread_rst_req;
  logic [7:0] out_data;

  always #2.5 clk = ~clk;

  sector_crc_guard #(.LEN_W(LEN_W)) uut (
    .clk(clk), .rst_n(rst_n), .idle(idle), .crc_en(crc_en), .rd_mode(rd_mode),
    .sect_len(sect_len), .in_valid(in_valid), .in_data(in_data), .in_ready(in_ready),
    .out_valid(out_valid), .out_data(out_data), .out_ready(out_ready),
    .data_err(data_err), .thread_rst_req(thread_rst_req));

  int checks = 0, fails = 0;
  logic [7:0] stim[$], expq[$], cap[$];
  bit m_en, m_rd, m_tail, m_mis, err_exp;
  int m_len, m_cnt;
  logic [63:0] m_crc;

  task automatic chk(input bit ok, input string req, input string what,
                     input longint act, input longint exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, exp);
    end
  endtask

  function automatic logic [63:0] crc_step(input logic [63:0] c, input logic [7:0] b);
    logic [63:0] r;
    r = c ^ {b, 56'h0};
    for (int k = 0; k < 8; k++) r = r[63] ? ((r << 1) ^ GEN) : (r << 1);
    return r;
  endfunction

  function automatic logic [7:0] crc_part(input logic [63:0] c, input int idx);
    return 8'((c >> (8 * (7 - idx))) & 64'hFF);
  endfunction

  task automatic model_in(input logic [7:0] b);
    if (!m_en) begin
      expq.push_back(b);
    end else if (!m_tail) begin
      m_crc = crc_step(m_crc, b);
      expq.push_back(b);
      m_cnt++;
      if (m_cnt == m_len) begin
        m_cnt = 0;
        if (m_rd) m_tail = 1'b1;
        else begin
          for (int i = 0; i < 8; i++) expq.push_back(crc_part(m_crc, i));
          m_crc = '0;
        end
      end
    end else begin
      if (b != crc_part(m_crc, m_cnt)) m_mis = 1'b1;
      m_cnt++;
      if (m_cnt == 8) begin
        err_exp = m_mis;
        m_mis = 1'b0; m_tail = 1'b0; m_cnt = 0; m_crc = '0;
      end
    end
  endtask

  task automatic run(input bit en, input bit rd, input int len, input int nsect,
                     input int bad_sect, input int bad_pos, input bit flip, input bit fixed);
    string tag;
    int guard;
    tag = !en ? "R2" : (rd ? "R4" : "R3");
    stim.delete(); expq.delete(); cap.delete();
    for (int s = 0; s < nsect; s++) begin
      logic [7:0] sec[$];
      logic [63:0] c;
      c = '0;
      for (int i = 0; i < len; i++) begin
        logic [7:0] b;
        b = fixed ? 8'(8'h31 + i) : 8'($urandom);
        sec.push_back(b);
        c = crc_step(c, b);
      end
      if (en && rd) for (int i = 0; i < 8; i++) sec.push_back(crc_part(c, i));
      if (s == bad_sect) sec[bad_pos] = sec[bad_pos] ^ 8'h5A;
      foreach (sec[i]) stim.push_back(sec[i]);
    end
    @(posedge clk); #1;
    idle = 1'b1; crc_en = en; rd_mode = rd; sect_len = LEN_W'(len);
    in_valid = 1'b1; in_data = 8'hAA; out_ready = 1'b1;
    @(negedge clk);
    chk(!in_ready && !out_valid, "R1", "idle blocks stream", {in_ready, out_valid}, 0);
    @(posedge clk); #1;
    idle = 1'b0;
    m_en = en; m_rd = rd; m_len = len; m_cnt = 0; m_tail = 0; m_mis = 0; m_crc = '0; err_exp = 0;
    if (flip) begin
      crc_en = !en; rd_mode = !rd; sect_len = LEN_W'(len + 3);
    end
    guard = 0;
    while ((stim.size() != 0 || expq.size() != 0) && guard < 5000) begin
      guard++;
      in_valid = (stim.size() != 0) && ($urandom % 4 != 0);
      in_data = (stim.size() != 0) ? stim[0] : 8'h00;
      out_ready = ($urandom % 4 != 0);
      @(negedge clk);
      chk(data_err == err_exp && thread_rst_req == err_exp, err_exp ? "R5" : "R6",
          "error pulse", {data_err, thread_rst_req}, {err_exp, err_exp});
      err_exp = 1'b0;
      if (in_valid && in_ready) model_in(stim.pop_front());
      if (out_valid && out_ready) begin
        if (expq.size() == 0) chk(1'b0, flip ? "R9" : tag, "unexpected byte", out_data, 0);
        else begin
          logic [7:0] e;
          e = expq.pop_front();
          chk(out_data == e, flip ? "R9" : tag, "output byte", out_data, e);
        end
        cap.push_back(out_data);
      end
      @(posedge clk); #1;
    end
    in_valid = 1'b0;
    @(negedge clk);
    chk(data_err == err_exp && thread_rst_req == err_exp, err_exp ? "R5" : "R6",
        "final error pulse", {data_err, thread_rst_req}, {err_exp, err_exp});
    err_exp = 1'b0;
    chk(stim.size() == 0 && expq.size() == 0, tag, "stream drained",
        stim.size() + expq.size(), 0);
    @(posedge clk); #1;
    idle = 1'b1;
  endtask

  initial begin
    #(5.0 * 190000);
    fails++;
    $display("FAIL watchdog expired");
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

  initial begin
    repeat (3) @(posedge clk);
    #1 rst_n = 1'b1;
    @(negedge clk);
    chk(!in_ready && !out_valid && !data_err && !thread_rst_req, "R1", "reset state",
        {in_ready, out_valid, data_err, thread_rst_req}, 0);
    // R2 bypass
    run(0, 0, 5, 4, -1, 0, 0, 0);
    chk(cap.size() == 20, "R2", "bypass byte count", cap.size(), 20);
    // R3 known check value
    run(1, 0, 9, 1, -1, 0, 0, 1);
    chk(cap.size() == 17, "R3", "write byte count", cap.size(), 17);
    if (cap.size() == 17) begin
      logic [63:0] got;
      got = '0;
      for (int i = 9; i < 17; i++) got = {got[55:0], cap[i]};
      chk(got == 64'h6C40DF5F0B497347, "R3", "check value", got, 64'h6C40DF5F0B497347);
    end
    // R7 R8 back-to-back sectors with stalls
    run(1, 0, 4, 3, -1, 0, 0, 0);
    chk(cap.size() == 36, "R7", "write multi-sector count", cap.size(), 36);
    // R4 R6 clean read
    run(1, 1, 6, 3, -1, 0, 0, 0);
    chk(cap.size() == 18, "R4", "read strip count", cap.size(), 18);
    // R5 corrupted payload
    run(1, 1, 6, 3, 1, 2, 0, 0);
    // R5 corrupted checksum byte
    run(1, 1, 5, 2, 0, 12, 0, 0);
    // R9 config changes mid-transfer
    run(1, 0, 3, 2, -1, 0, 1, 0);
    chk(cap.size() == 22, "R9", "latched config count", cap.size(), 22);
    // R7 single-byte sectors in read mode
    run(1, 1, 1, 4, 2, 8, 0, 0);
    chk(cap.size() == 4, "R7", "one-byte sectors", cap.size(), 4);
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end
endmodule